// File: doc/BRIEF.md
# DRAM page-hit burst address generator

This block produces a stream of memory request addresses with a read/write flag. The stream is shaped so that a DRAM controller sees a chosen page-hit length. Requests come in series. At the start of each series the block draws a random base address from a configured window, a random bank among the banks in use, a random rank and a random starting column. It packs the bank, rank and column into the address according to one of two field layouts. It then walks N successive columns of the same page, one request per handshake. The starting column is limited so that the last column of a series never crosses the page end.

Requests leave on a valid/ready stream. Once `req_valid` is high, the address and flag are held unchanged until `req_ready` is seen high on a clock edge, and each such edge consumes one request. The sender never withdraws a request it has offered. While `en` is high, the next series follows the final request of the previous one with no idle cycle. When `en` goes low, a series already in progress still runs to its end, and no new series starts. Configuration inputs are plain levels. They are sampled on the edge where a series starts.

Random values come from a free-running 32-bit LFSR. Each range is reduced from it with a modulo.

Top module: `pgburst_gen`

## Requirements
- R1: A series has N = `cfg_len` requests, with 0 read as 1 and values above the columns per page (32 by default) read as 32. Exactly N handshakes make up one series. While `en` is high, `req_valid` is high on every cycle after the edge that saw `en`, so a new series starts on the same edge as the last handshake of the previous one.
- R2: Every request address has its burst-offset bits (bits 4:0 by default) at zero. The address bits above the packed fields (bits 31:14 by default) lie between those of `cfg_lo` and of `cfg_hi`-1. When `cfg_hi` <= `cfg_lo`, they equal those of `cfg_lo`.
- R3: The bank field of each request is below the number of banks in use. That number is `cfg_banks`, with 0 read as 1 and values above BANKS (8) read as BANKS.
- R4: The starting column of a series is at most (columns per page - N), so all N requests fall in one page.
- R5: When `cfg_map` is 1, the fields from bit 0 upward are offset [4:0], column [9:5], bank [12:10] and rank [13]. When `cfg_map` is 0, they are offset [4:0], bank [7:5], rank [8] and column [13:9] (defaults shown). Each request after the first in a series equals the previous one with the column field raised by one and all other bits unchanged.
- R6: A `cfg_map` value of 2 or 3 produces the same layout and column walk as value 1.
- R7: `req_rd` is chosen once per series and stays constant within it. `cfg_rd_pct` = 0 gives only writes (`req_rd`=0). A value of 100 or more gives only reads (`req_rd`=1). A value of 50 gives both over many series.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_rd` keep their values on the next cycle.
- R9: With `en` low and no request pending, `req_valid` stays low. A series in progress when `en` drops runs to completion and then `req_valid` goes low.
- R10: After reset, `req_valid` is low.
- R11: Mapping, length, bank count, read percentage and address window are sampled on the edge where a series starts. Changing them during the series does not affect that series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables the start of new series |
| cfg_map | input | 2 | Field layout select: 0 column above bank/rank; any other value column just above offset |
| cfg_len | input | LEN_W (6) | Requests per series |
| cfg_banks | input | BNKC_W (4) | Number of banks in use |
| cfg_rd_pct | input | 7 | Read percentage |
| cfg_lo | input | ADDR_W (32) | Lower bound of the base address window |
| cfg_hi | input | ADDR_W (32) | Exclusive upper bound of the base address window |
| req_valid | output | 1 | A request is offered |
| req_ready | input | 1 | Consumer accepts the request on this edge |
| req_addr | output | ADDR_W (32) | Request address |
| req_rd | output | 1 | 1 for a read, 0 for a write |

## Verification
Full-page series (N equal to the columns per page) force the starting column to zero. A design with an off-by-one in the column range would step past the page end and change the bank or row bits. Length and bank values of 0 and above the limit check the clamps. Without them, a series would never end or would draw from a modulo by zero. The map codes 2 and 3, an empty address window, and an `en` pulse of one cycle check the fallback layout, the degenerate window and the exact handshake count. A design that took any of these wrong would put fields at the wrong bit positions, or issue one request too many or too few. A long random phase changes every configuration input mid-series under random back-pressure. This catches a design that reads the layout or length live instead of sampling it at the series start, and one that lets the address move while stalled.

// File: rtl/pgburst_pkg.sv
package pgburst_pkg;

  localparam int RND_W = 32;

  // Layout of the packed fields above the burst offset.
  typedef enum logic {
    MAP_COL_ABOVE = 1'b0,  // offset, bank, rank, column
    MAP_COL_BELOW = 1'b1   // offset, column, bank, rank
  } map_e;

  // Code 0 selects the column-above layout; every other code falls back.
  function automatic map_e decode_map(input logic [1:0] code);
    return (code == 2'd0) ? MAP_COL_ABOVE : MAP_COL_BELOW;
  endfunction

endpackage

// File: rtl/pgburst_lfsr.sv
module pgburst_lfsr #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   SEED = W'(32'h1ACE_B00C),
  // Top bit set keeps a non-zero state from ever reaching zero.
  parameter logic [W-1:0]   MASK = W'(32'hA300_0000)
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= (state >> 1) ^ (state[0] ? MASK : '0);
  end

endmodule

// File: rtl/pgburst_start.sv
module pgburst_start
  import pgburst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 5,
  parameter int COL_W  = 5,
  parameter int BANK_W = 3,
  parameter int RANK_W = 1,
  parameter int COLS   = 32,
  parameter int RANKS  = 2,
  parameter int LEN_W  = 6,
  parameter int BNKC_W = 4
) (
  input  logic [RND_W-1:0]  rnd,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [LEN_W-1:0]  len_eff,
  input  logic [BNKC_W-1:0] banks_eff,
  input  map_e              map,
  output logic [ADDR_W-1:0] start_addr
);

  localparam int C1 = BLK_W;            // column, layout below
  localparam int B1 = BLK_W + COL_W;    // bank, layout below
  localparam int R1 = B1 + BANK_W;      // rank, layout below
  localparam int B0 = BLK_W;            // bank, layout above
  localparam int R0 = BLK_W + BANK_W;   // rank, layout above
  localparam int C0 = R0 + RANK_W;      // column, layout above

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] body;
  logic [LEN_W:0]    col_span;
  logic [COL_W-1:0]  col;
  logic [BANK_W-1:0] bank;

  always_comb begin
    span     = hi - lo;
    offs     = (hi > lo) ? (ADDR_W'(rnd) % span) : '0;
    base     = lo + offs;
    aligned  = {base[ADDR_W-1:BLK_W], BLK_W'(0)};
    // room for len_eff columns: start in 0 .. COLS-len_eff
    col_span = (LEN_W+1)'(COLS + 1) - (LEN_W+1)'(len_eff);
    col      = COL_W'(rnd[31:16] % 16'(col_span));
    bank     = BANK_W'(rnd[26:11] % 16'(banks_eff));
  end

  always_comb begin
    body = aligned;
    if (map == MAP_COL_BELOW) begin
      body[C1 +: COL_W]  = col;
      body[B1 +: BANK_W] = bank;
    end else begin
      body[B0 +: BANK_W] = bank;
      body[C0 +: COL_W]  = col;
    end
  end

  generate
    if (RANK_W > 0) begin : g_rank
      logic [RANK_W-1:0] rank;
      always_comb begin
        rank       = RANK_W'(rnd[13:0] % 14'(RANKS));
        start_addr = body;
        if (map == MAP_COL_BELOW) start_addr[R1 +: RANK_W] = rank;
        else                      start_addr[R0 +: RANK_W] = rank;
      end
    end else begin : g_norank
      assign start_addr = body;
    end
  endgenerate

endmodule

// File: rtl/pgburst_step.sv
module pgburst_step
  import pgburst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 5,
  parameter int COL_W  = 5,
  parameter int BANK_W = 3,
  parameter int RANK_W = 1
) (
  input  logic [ADDR_W-1:0] cur,
  input  map_e              map,
  output logic [ADDR_W-1:0] nxt
);

  localparam int C0 = BLK_W + BANK_W + RANK_W;

  logic [COL_W-1:0] col_up;

  always_comb begin
    // column above bank/rank: lift the field out, bump, write back
    col_up = cur[C0 +: COL_W] + COL_W'(1);
    nxt    = cur;
    if (map == MAP_COL_BELOW) nxt = cur + (ADDR_W'(1) << BLK_W);
    else                      nxt[C0 +: COL_W] = col_up;
  end

endmodule

// File: rtl/pgburst_gen.sv
module pgburst_gen
  import pgburst_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int               BURST_BYTES = 32,
  parameter int               PAGE_BYTES  = 1024,
  parameter int               BANKS       = 8,
  parameter int               RANKS       = 2,
  parameter logic [RND_W-1:0] SEED        = 32'h1ACE_B00C,
  localparam int              COLS        = PAGE_BYTES / BURST_BYTES,
  localparam int              LEN_W       = $clog2(COLS + 1),
  localparam int              BNKC_W      = $clog2(BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        cfg_map,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [BNKC_W-1:0] cfg_banks,
  input  logic [6:0]        cfg_rd_pct,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_rd
);

  localparam int BLK_W  = $clog2(BURST_BYTES);
  localparam int COL_W  = $clog2(COLS);
  localparam int BANK_W = $clog2(BANKS);
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 0;

  logic [RND_W-1:0]  rnd;
  logic [LEN_W-1:0]  len_eff;
  logic [BNKC_W-1:0] banks_eff;
  map_e              map_now;
  logic              rd_pick;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] step_addr;

  logic              valid_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  cnt_q;   // requests left in the series, current one included
  map_e              map_q;

  logic fire;
  logic last_beat;
  logic start_now;

  pgburst_lfsr #(.W(RND_W), .SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .state (rnd)
  );

  always_comb begin
    if (cfg_len == '0)                    len_eff = LEN_W'(1);
    else if (cfg_len > LEN_W'(COLS))      len_eff = LEN_W'(COLS);
    else                                  len_eff = cfg_len;
    if (cfg_banks == '0)                  banks_eff = BNKC_W'(1);
    else if (cfg_banks > BNKC_W'(BANKS))  banks_eff = BNKC_W'(BANKS);
    else                                  banks_eff = cfg_banks;
    map_now = decode_map(cfg_map);
    rd_pick = (rnd[21:6] % 16'd100) < 16'(cfg_rd_pct);
  end

  pgburst_start #(
    .ADDR_W (ADDR_W), .BLK_W (BLK_W), .COL_W (COL_W), .BANK_W (BANK_W),
    .RANK_W (RANK_W), .COLS (COLS), .RANKS (RANKS), .LEN_W (LEN_W),
    .BNKC_W (BNKC_W)
  ) u_start (
    .rnd        (rnd),
    .lo         (cfg_lo),
    .hi         (cfg_hi),
    .len_eff    (len_eff),
    .banks_eff  (banks_eff),
    .map        (map_now),
    .start_addr (start_addr)
  );

  pgburst_step #(
    .ADDR_W (ADDR_W), .BLK_W (BLK_W), .COL_W (COL_W), .BANK_W (BANK_W),
    .RANK_W (RANK_W)
  ) u_step (
    .cur (addr_q),
    .map (map_q),
    .nxt (step_addr)
  );

  assign fire      = valid_q && req_ready;
  assign last_beat = fire && (cnt_q == LEN_W'(1));
  assign start_now = en && (!valid_q || last_beat);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      map_q   <= MAP_COL_BELOW;
    end else if (start_now) begin
      valid_q <= 1'b1;
      rd_q    <= rd_pick;
      addr_q  <= start_addr;
      cnt_q   <= len_eff;
      map_q   <= map_now;
    end else if (fire) begin
      if (last_beat) begin
        valid_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        addr_q  <= step_addr;
        cnt_q   <= cnt_q - LEN_W'(1);
      end
    end
  end

  assign req_valid = valid_q;
  assign req_addr  = addr_q;
  assign req_rd    = rd_q;

endmodule

// File: rtl/pgburst_chk.sv
module pgburst_chk
  import pgburst_pkg::*;
#(
  parameter int  ADDR_W      = 32,
  parameter int  BURST_BYTES = 32,
  parameter int  PAGE_BYTES  = 1024,
  parameter int  BANKS       = 8,
  parameter int  RANKS       = 2,
  localparam int COLS        = PAGE_BYTES / BURST_BYTES,
  localparam int LEN_W       = $clog2(COLS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_rd,
  input logic [LEN_W-1:0]  cnt_q,
  input map_e              map_q
);

  localparam int BLK_W  = $clog2(BURST_BYTES);
  localparam int COL_W  = $clog2(COLS);
  localparam int BANK_W = $clog2(BANKS);
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 0;
  localparam int C0     = BLK_W + BANK_W + RANK_W;

  logic [COL_W-1:0] col;
  always_comb col = (map_q == MAP_COL_BELOW) ? req_addr[BLK_W +: COL_W]
                                             : req_addr[C0 +: COL_W];

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !req_valid); // R10

  AST_ENABLED_BUSY: assert property (@(posedge clk) disable iff (rst)
    en |=> req_valid); // R1

  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> cnt_q != '0); // R1

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_addr[BLK_W-1:0] == '0); // R2

  AST_COL_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (int'(col) + int'(cnt_q)) <= COLS); // R4

  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && cnt_q > LEN_W'(1) |=> req_valid && col == COL_W'($past(col) + COL_W'(1))); // R5

  AST_RW_SERIES: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && cnt_q > LEN_W'(1) |=> $stable(req_rd)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_rd)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid && !en |=> !req_valid); // R9

endmodule

bind pgburst_gen pgburst_chk #(
  .ADDR_W (ADDR_W), .BURST_BYTES (BURST_BYTES), .PAGE_BYTES (PAGE_BYTES),
  .BANKS (BANKS), .RANKS (RANKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_rd    (req_rd),
  .cnt_q     (cnt_q),
  .map_q     (map_q)
);

// File: tb/tb_pgburst_gen.sv
`timescale 1ns/1ps
module tb_pgburst_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  cfg_map = 2'd1;
  logic [5:0]  cfg_len = 6'd4;
  logic [3:0]  cfg_banks = 4'd8;
  logic [6:0]  cfg_rd_pct = 7'd100;
  logic [31:0] cfg_lo = 32'h0;
  logic [31:0] cfg_hi = 32'h0010_0000;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic        req_rd;

  always #2.5 clk = ~clk;  // 200 MHz

  pgburst_gen dut (
    .clk (clk), .rst (rst), .en (en), .cfg_map (cfg_map), .cfg_len (cfg_len),
    .cfg_banks (cfg_banks), .cfg_rd_pct (cfg_rd_pct), .cfg_lo (cfg_lo),
    .cfg_hi (cfg_hi), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_rd (req_rd)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // model state
  int          rem = 0;
  bit          need_start = 1;
  bit          need_next = 0;
  int          s_len, s_map, s_code;
  bit          s_rd;
  bit          cfg_moved = 0;
  logic [31:0] last_addr;
  bit          prev_stall = 0;
  bit          prev_valid = 0;
  logic [31:0] prev_addr;
  bit          prev_rd;
  int          ready_pct = 70;
  bit          rand_cfg = 0;
  int          hs_count = 0;
  int          rd_seen = 0;
  int          wr_seen = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int len_of(int l);
    return (l == 0) ? 1 : ((l > 32) ? 32 : l);
  endfunction
  function automatic int banks_of(int b);
    return (b == 0) ? 1 : ((b > 8) ? 8 : b);
  endfunction
  function automatic int col_of(logic [31:0] a, int m);
    return (m == 0) ? int'(a[13:9]) : int'(a[9:5]);
  endfunction
  function automatic int bank_of(logic [31:0] a, int m);
    return (m == 0) ? int'(a[7:5]) : int'(a[12:10]);
  endfunction
  function automatic logic [31:0] with_col(logic [31:0] a, int m, int c);
    logic [31:0] r = a;
    if (m == 0) r[13:9] = 5'(c);
    else        r[9:5]  = 5'(c);
    return r;
  endfunction

  task automatic randomize_cfg();
    cfg_map   = 2'($urandom_range(3));
    cfg_len   = 6'($urandom_range(40));
    cfg_banks = 4'($urandom_range(15));
    case ($urandom_range(3))
      0:       cfg_rd_pct = 7'd0;
      1:       cfg_rd_pct = 7'd50;
      2:       cfg_rd_pct = 7'd100;
      default: cfg_rd_pct = 7'($urandom_range(127));
    endcase
    cfg_lo = $urandom;
    cfg_hi = $urandom;
    if (!need_start) cfg_moved = 1;
  endtask

  task automatic tick();
    bit r;
    logic [31:0] lo_t, hi_t, exp_a;
    @(negedge clk);
    if (en) chk(req_valid == 1'b1, "R1", "valid while enabled", req_valid, 1);
    else if (!prev_valid) chk(req_valid == 1'b0, "R9", "no start while disabled", req_valid, 0);
    if (prev_stall)
      chk(req_valid && req_addr == prev_addr && req_rd == prev_rd, "R8", "held request", req_addr, prev_addr);
    if (!req_valid) chk(need_start && rem == 0, "R1", "series cut short", rem, 0);

    if (req_valid && need_start) begin
      s_code = int'(cfg_map);
      s_map  = (cfg_map == 2'd0) ? 0 : 1;
      s_len  = len_of(int'(cfg_len));
      cfg_moved = 0;
      chk(req_addr[4:0] == 5'd0, "R2", "burst offset", req_addr[4:0], 0);
      lo_t = cfg_lo >> 14;
      hi_t = (cfg_hi > cfg_lo) ? ((cfg_hi - 32'd1) >> 14) : lo_t;
      chk((req_addr >> 14) >= lo_t && (req_addr >> 14) <= hi_t, "R2", "upper bits in window", req_addr >> 14, lo_t);
      chk(bank_of(req_addr, s_map) < banks_of(int'(cfg_banks)), "R3", "bank in use",
          bank_of(req_addr, s_map), banks_of(int'(cfg_banks)) - 1);
      chk(col_of(req_addr, s_map) <= 32 - s_len, "R4", "start column", col_of(req_addr, s_map), 32 - s_len);
      if (cfg_rd_pct == 7'd0)        chk(req_rd == 1'b0, "R7", "write only", req_rd, 0);
      else if (cfg_rd_pct >= 7'd100) chk(req_rd == 1'b1, "R7", "read only", req_rd, 1);
      if (req_rd) rd_seen++; else wr_seen++;
      s_rd = req_rd;
      rem = s_len;
      need_start = 0;
      last_addr = req_addr;
    end else if (req_valid && need_next) begin
      exp_a = with_col(last_addr, s_map, col_of(last_addr, s_map) + 1);
      if (cfg_moved)        chk(req_addr == exp_a, "R11", "series kept its config", req_addr, exp_a);
      else if (s_code >= 2) chk(req_addr == exp_a, "R6", "fallback layout step", req_addr, exp_a);
      else                  chk(req_addr == exp_a, "R5", "column step", req_addr, exp_a);
      chk(req_rd == s_rd, "R7", "flag constant in series", req_rd, s_rd);
      need_next = 0;
      last_addr = req_addr;
    end

    r = ($urandom_range(99) < ready_pct);
    req_ready = r;
    if (req_valid && r) begin
      hs_count++;
      rem--;
      if (rem == 0) need_start = 1;
      else          need_next = 1;
    end
    prev_stall = req_valid && !r;
    prev_valid = req_valid;
    prev_addr  = req_addr;
    prev_rd    = req_rd;
    if (rand_cfg && $urandom_range(15) == 0) randomize_cfg();
  endtask

  task automatic drain();
    en = 1'b0;
    ready_pct = 100;
    for (int i = 0; i < 80; i++) begin
      tick();
      if (!req_valid && need_start) break;
    end
    chk(!req_valid && need_start && rem == 0, "R9", "series completes then idles", req_valid, 0);
  endtask

  task automatic phase(int m, int l, int b, int p, logic [31:0] lo, logic [31:0] hi, int n, int rp);
    cfg_map = 2'(m); cfg_len = 6'(l); cfg_banks = 4'(b); cfg_rd_pct = 7'(p);
    cfg_lo = lo; cfg_hi = hi;
    ready_pct = rp;
    en = 1'b1;
    repeat (n) tick();
    drain();
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk(req_valid == 1'b0, "R10", "valid in reset", req_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b0, "R10", "valid after reset", req_valid, 0);
    repeat (10) tick();
    chk(req_valid == 1'b0 && hs_count == 0, "R9", "idle while disabled", req_valid, 0);

    // R5 layout with column low, all reads
    phase(1, 4, 8, 100, 32'h0, 32'h0010_0000, 300, 70);
    // R5 layout with column high, few banks, all writes
    phase(0, 6, 3, 0, 32'h4000_0000, 32'h4800_0000, 300, 60);
    // R4 full page, R6 code 2, R2 empty window
    phase(2, 32, 1, 100, 32'h1234_5678, 32'h0, 300, 80);
    // R1/R3 clamps at zero, R6 code 3
    phase(3, 0, 0, 0, 32'h8000_0000, 32'h8000_4000, 200, 50);
    // R1/R3 clamps above the limit, R7 mixed flags
    rd_seen = 0; wr_seen = 0;
    phase(0, 40, 15, 50, 32'h0, 32'hFFFF_FFFF, 400, 90);
    chk(rd_seen > 0 && wr_seen > 0, "R7", "both reads and writes at 50", rd_seen * 1000 + wr_seen, 1);

    // R1 exact count for one pulse of en
    cfg_map = 2'd1; cfg_len = 6'd5; cfg_banks = 4'd4; cfg_rd_pct = 7'd0;
    hs_count = 0; ready_pct = 100;
    en = 1'b1;
    tick();
    en = 1'b0;
    repeat (30) tick();
    chk(hs_count == 5, "R1", "handshakes for one series", hs_count, 5);

    // R11 random config changes mid-series under random back-pressure
    rand_cfg = 1;
    phase(1, 8, 8, 50, 32'h0, 32'h0100_0000, 2000, 50);
    rand_cfg = 0;
    drain();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule